// File: doc/BRIEF.md
# Single-Cycle 32-Bit Integer Core

This block is a small 32-bit processor that retires one instruction on every rising clock edge. It executes a fixed integer subset: register-register add, subtract, AND, OR, set-less-than and left shift by a constant; add-immediate; word load and store; branch on equal and on not-equal; and a direct jump with or without a return link. The core holds its program counter, a 32-entry register file, an ALU with its operation decoder, the main instruction decoder, and separate word-wide instruction and data memories kept as internal arrays.

A test harness uses the program port to fill instruction memory while the core is held in reset, then releases reset and lets the program run. Two observation ports return any register and any data-memory word combinationally, and the program counter is brought out directly. The second ALU operand select is two bits wide so that it can carry the shift amount. The branch control is also two bits wide, so that a single equality comparator serves both branch kinds.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low the program counter is 0 and every register reads 0; the core starts fetching at address 0 after `rst_n` rises.
- R2: Opcode 0 with funct 100000 (add), 100010 (sub), 100100 (and), 100101 (or) or 101010 (signed set-less-than, result 1 or 0) writes the result for rs and rt into rd.
- R3: Opcode 0 with funct 000000 writes into rd the register selected by rs [25:21], shifted left by shamt [10:6].
- R4: Opcode 8 writes into rt [20:16] the value of rs plus the sign-extended 16-bit immediate [15:0].
- R5: Opcode 43 stores rt into the data word at byte address rs + sign-extended immediate. Opcode 35 loads that word into rt. The word index is the address divided by 4.
- R6: Opcode 4 (equal) and opcode 5 (not equal) compare rs with rt. When taken, the next PC is PC+4 plus the sign-extended immediate shifted left by 2; otherwise it is PC+4.
- R7: Opcode 2 jumps to {PC+4 [31:28], target [25:0], 00}. Opcode 3 does the same and also writes PC+4 into register 31.
- R8: Register 0 always reads 0, and a write aimed at it has no effect.
- R9: Stores, branches and unknown opcodes leave every register unchanged. An unknown opcode advances the PC by 4.
- R10: A word written through the program port while the core is in reset is later executed from that word index. The register and memory observation ports return the current contents with no delay.
- R11: Apart from taken branches and jumps, the PC advances by 4 on each rising edge, and it always stays word-aligned.
- R12: A register written by one instruction holds its old value until that instruction's clock edge and its new value from the next instruction onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_we | input | 1 | Write enable of the program port |
| prog_idx | input | IMEM_AW | Instruction word index to write |
| prog_word | input | 32 | Instruction word to write |
| peek_reg | input | 5 | Register number to observe |
| peek_reg_val | output | 32 | Current value of that register |
| peek_mem | input | DMEM_AW | Data-memory word index to observe |
| peek_mem_val | output | 32 | Current value of that data word |
| pc_now | output | 32 | Current program counter |

## Verification
A single program mixes every instruction kind with operands chosen to separate the operations: a positive and a negative value make add, subtract, AND, OR and both orders of signed set-less-than give different results, and the shift moves a non-trivial pattern. Branches are tried both taken and not taken, with an instruction placed in each skipped slot whose effect would be visible. The link value is checked against the fetch address of the jump. Writes to register 0, stores whose source register would be overwritten by a stray write, and an unknown opcode show that nothing is written where nothing should be. Reset and the first fetch step are checked directly at the ports.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_J     = 6'd2;
  localparam logic [5:0] OP_JAL   = 6'd3;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_BNE   = 6'd5;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_LW    = 6'd35;
  localparam logic [5:0] OP_SW    = 6'd43;

  localparam logic [5:0] FN_SLL = 6'b000000;
  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SLL = 4'b0011,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111,
    ALU_NOR = 4'b1100
  } alu_fn_e;

  typedef enum logic [1:0] { SRC_REG = 2'b00, SRC_IMM = 2'b01, SRC_SHAMT = 2'b10 } opb_sel_e;
  typedef enum logic [1:0] { DST_RT = 2'b00, DST_RD = 2'b01, DST_LINK = 2'b10 } dst_sel_e;
  typedef enum logic [1:0] { WB_ALU = 2'b00, WB_MEM = 2'b01, WB_PC4 = 2'b10 } wb_sel_e;
  typedef enum logic [1:0] { BR_NONE = 2'b00, BR_EQ = 2'b10, BR_NE = 2'b11 } br_sel_e;

  typedef struct packed {
    logic     reg_we;
    dst_sel_e dst;
    wb_sel_e  wb;
    opb_sel_e opb;
    logic [1:0] alu_class;
    logic     mem_we;
    br_sel_e  br;
    logic     jump;
  } ctl_t;

  function automatic logic [31:0] sext16(input logic [15:0] imm);
    return {{16{imm[15]}}, imm};
  endfunction

  function automatic logic [31:0] branch_dest(input logic [31:0] pc4, input logic [15:0] imm);
    return pc4 + {sext16(imm)[29:0], 2'b00};
  endfunction

  function automatic logic [31:0] jump_dest(input logic [31:0] pc4, input logic [25:0] tgt);
    return {pc4[31:28], tgt, 2'b00};
  endfunction

  function automatic logic br_decide(input br_sel_e br, input logic equal);
    return br[1] & (equal ^ br[0]);
  endfunction
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctl_t       ctl,
  output alu_fn_e    alu_fn
);
  always_comb begin
    ctl = '{reg_we: 1'b0, dst: DST_RT, wb: WB_ALU, opb: SRC_REG,
            alu_class: 2'b00, mem_we: 1'b0, br: BR_NONE, jump: 1'b0};
    unique case (opcode)
      OP_RTYPE: begin
        ctl.reg_we = 1'b1; ctl.dst = DST_RD; ctl.alu_class = 2'b10;
        if (funct == FN_SLL) ctl.opb = SRC_SHAMT;
      end
      OP_LW:   begin ctl.reg_we = 1'b1; ctl.wb = WB_MEM; ctl.opb = SRC_IMM; end
      OP_SW:   begin ctl.mem_we = 1'b1; ctl.opb = SRC_IMM; end
      OP_ADDI: begin ctl.reg_we = 1'b1; ctl.opb = SRC_IMM; end
      OP_BEQ:  begin ctl.alu_class = 2'b01; ctl.br = BR_EQ; end
      OP_BNE:  begin ctl.alu_class = 2'b01; ctl.br = BR_NE; end
      OP_J:    ctl.jump = 1'b1;
      OP_JAL:  begin ctl.jump = 1'b1; ctl.reg_we = 1'b1; ctl.dst = DST_LINK; ctl.wb = WB_PC4; end
      default: ;
    endcase
  end

  always_comb begin
    unique case (ctl.alu_class)
      2'b01: alu_fn = ALU_SUB;
      2'b10: begin
        unique case (funct)
          FN_SUB:  alu_fn = ALU_SUB;
          FN_AND:  alu_fn = ALU_AND;
          FN_OR:   alu_fn = ALU_OR;
          FN_SLT:  alu_fn = ALU_SLT;
          FN_SLL:  alu_fn = ALU_SLL;
          default: alu_fn = ALU_ADD;
        endcase
      end
      default: alu_fn = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         zero
);
  localparam int SHW = $clog2(W);

  always_comb begin
    unique case (fn)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, $signed(a) < $signed(b)};
      ALU_SLL: y = a << b[SHW-1:0];
      ALU_NOR: y = ~(a | b);
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  input  logic [AW-1:0] ra_c,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  output logic [W-1:0]  rd_c,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [NREG];
  logic         wr_live;

  assign wr_live = we && (wa != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_live) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];
  assign rd_c = (ra_c == '0) ? '0 : regs[ra_c];

  p_write_lands_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_live |=> regs[$past(wa)] == $past(wd));
  p_zero_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_c == '0) |-> (rd_c == '0));
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 64,
  localparam int IMEM_AW = $clog2(IMEM_DEPTH),
  localparam int DMEM_AW = $clog2(DMEM_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_we,
  input  logic [IMEM_AW-1:0] prog_idx,
  input  logic [31:0]        prog_word,
  input  logic [4:0]         peek_reg,
  output logic [31:0]        peek_reg_val,
  input  logic [DMEM_AW-1:0] peek_mem,
  output logic [31:0]        peek_mem_val,
  output logic [31:0]        pc_now
);
  logic [31:0] imem [IMEM_DEPTH];
  logic [31:0] dmem [DMEM_DEPTH];
  logic [31:0] pc, pc4, pc_next, instr;
  logic [31:0] rs_val, rt_val, opb, alu_y, wb_data, mem_rd;
  logic [31:0] br_target, j_target;
  logic [4:0]  wr_reg;
  logic        alu_zero, br_taken;
  logic [DMEM_AW-1:0] mem_idx;
  ctl_t        ctl;
  alu_fn_e     alu_fn;
  logic        unused_bits;

  assign instr = imem[pc[IMEM_AW+1:2]];
  assign pc4   = pc + 32'd4;
  assign unused_bits = ^{pc[1:0], pc[31:IMEM_AW+2], alu_y[1:0]};

  always_ff @(posedge clk) begin
    if (prog_we) imem[prog_idx] <= prog_word;
  end

  sc_decode u_dec (
    .opcode(instr[31:26]), .funct(instr[5:0]), .ctl(ctl), .alu_fn(alu_fn)
  );

  always_comb begin
    unique case (ctl.dst)
      DST_RD:   wr_reg = instr[15:11];
      DST_LINK: wr_reg = 5'd31;
      default:  wr_reg = instr[20:16];
    endcase
  end

  sc_regfile #(.W(32), .NREG(32)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_a(instr[25:21]), .ra_b(instr[20:16]), .ra_c(peek_reg),
    .rd_a(rs_val), .rd_b(rt_val), .rd_c(peek_reg_val),
    .we(ctl.reg_we), .wa(wr_reg), .wd(wb_data)
  );

  always_comb begin
    unique case (ctl.opb)
      SRC_IMM:   opb = sext16(instr[15:0]);
      SRC_SHAMT: opb = {27'd0, instr[10:6]};
      default:   opb = rt_val;
    endcase
  end

  sc_alu #(.W(32)) u_alu (.a(rs_val), .b(opb), .fn(alu_fn), .y(alu_y), .zero(alu_zero));

  assign mem_idx = alu_y[DMEM_AW+1:2];
  assign mem_rd  = dmem[mem_idx];

  always_ff @(posedge clk) begin
    if (rst_n && ctl.mem_we) dmem[mem_idx] <= rt_val;
  end

  always_comb begin
    unique case (ctl.wb)
      WB_MEM:  wb_data = mem_rd;
      WB_PC4:  wb_data = pc4;
      default: wb_data = alu_y;
    endcase
  end

  assign br_target = branch_dest(pc4, instr[15:0]);
  assign j_target  = jump_dest(pc4, instr[25:0]);
  assign br_taken  = br_decide(ctl.br, alu_zero);

  always_comb begin
    if (ctl.jump)      pc_next = j_target;
    else if (br_taken) pc_next = br_target;
    else               pc_next = pc4;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_next;
  end

  assign pc_now       = pc;
  assign peek_mem_val = dmem[peek_mem];

  p_pc_aligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00);
  p_pc_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.jump && !br_taken) |=> pc == $past(pc) + 32'd4);
  p_branch_eq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.br == BR_EQ && rs_val == rt_val) |-> br_taken);
  p_branch_ne_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.br == BR_NE && rs_val == rt_val) |-> !br_taken);
  p_quiet_ops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[31:26] == OP_SW || instr[31:26] == OP_BEQ || instr[31:26] == OP_BNE) |-> !ctl.reg_we);
  p_store_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.mem_we |=> dmem[$past(mem_idx)] == $past(rt_val));
  p_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[31:26] == OP_JAL) |-> (wr_reg == 5'd31 && wb_data == pc + 32'd4));
endmodule

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;
  localparam int IAW = 6;
  localparam int DAW = 6;
  localparam int NCHK = 18;
  localparam int PLEN = 27;

  // register-content expectations after the program has run
  localparam int CHK_REG [NCHK] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 0, 12, 13, 14, 15, 16, 31};
  localparam logic [31:0] CHK_VAL [NCHK] = '{
    32'd5, 32'hFFFF_FFFD, 32'd2, 32'd8, 32'd5, 32'hFFFF_FFFD, 32'd1, 32'd0,
    32'd80, 32'd16, 32'd8, 32'd0, 32'd1, 32'd0, 32'd0, 32'hFFFF_FFFF, 32'd0, 32'd80};
  string chk_tag [NCHK] = '{"R4", "R4", "R2", "R9", "R2", "R2", "R2", "R2",
                            "R3", "R4", "R5", "R8", "R6", "R6", "R7", "R12", "R9", "R7"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_we = 1'b0;
  logic [IAW-1:0] prog_idx = '0;
  logic [31:0] prog_word = '0;
  logic [4:0] peek_reg = '0;
  logic [31:0] peek_reg_val;
  logic [DAW-1:0] peek_mem = '0;
  logic [31:0] peek_mem_val, pc_now;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  logic [31:0] prog [PLEN];

  always #4 clk = ~clk;

  sc_core #(.IMEM_DEPTH(64), .DMEM_DEPTH(64)) uut (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_idx(prog_idx),
    .prog_word(prog_word), .peek_reg(peek_reg), .peek_reg_val(peek_reg_val),
    .peek_mem(peek_mem), .peek_mem_val(peek_mem_val), .pc_now(pc_now)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] enc_j(int op, int tgt);
    return {op[5:0], tgt[25:0]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic read_reg(int r, output logic [31:0] v);
    @(negedge clk);
    peek_reg = r[4:0];
    #1 v = peek_reg_val;
  endtask

  initial begin
    #(8 * 5000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    prog[0]  = enc_i(8, 0, 1, 5);
    prog[1]  = enc_i(8, 0, 2, -3);
    prog[2]  = enc_r(1, 2, 3, 0, 6'b100000);
    prog[3]  = enc_r(1, 2, 4, 0, 6'b100010);
    prog[4]  = enc_r(1, 2, 5, 0, 6'b100100);
    prog[5]  = enc_r(1, 2, 6, 0, 6'b100101);
    prog[6]  = enc_r(2, 1, 7, 0, 6'b101010);
    prog[7]  = enc_r(1, 2, 8, 0, 6'b101010);
    prog[8]  = enc_r(1, 0, 9, 4, 6'b000000);
    prog[9]  = enc_i(8, 0, 10, 16);
    prog[10] = enc_i(43, 10, 4, 4);
    prog[11] = enc_i(35, 10, 11, 4);
    prog[12] = enc_i(8, 0, 0, 7);
    prog[13] = enc_i(4, 1, 2, 1);
    prog[14] = enc_i(8, 0, 12, 1);
    prog[15] = enc_i(5, 1, 2, 1);
    prog[16] = enc_i(8, 0, 13, 99);
    prog[17] = enc_i(4, 3, 3, 1);
    prog[18] = enc_i(8, 0, 13, 77);
    prog[19] = enc_j(3, 22);
    prog[20] = enc_i(8, 0, 14, 55);
    prog[21] = enc_i(8, 0, 14, 66);
    prog[22] = enc_i(43, 0, 9, 0);
    prog[23] = enc_i(63, 0, 16, 5);
    prog[24] = enc_i(5, 1, 1, -10);
    prog[25] = enc_i(8, 15, 15, -1);
    prog[26] = enc_j(2, 26);

    // R1: reset state at the ports
    repeat (2) @(negedge clk);
    check("R1 pc in reset", pc_now, 32'd0);
    read_reg(1, v);
    check("R1 reg in reset", v, 32'd0);

    // R10: program loaded through the port while in reset
    for (int i = 0; i < PLEN; i++) begin
      @(negedge clk);
      prog_we = 1'b1; prog_idx = i[IAW-1:0]; prog_word = prog[i];
    end
    @(negedge clk);
    prog_we = 1'b0;

    rst_n = 1'b1;
    @(negedge clk);
    check("R11 first step", pc_now, 32'd4);
    @(negedge clk);
    check("R11 second step", pc_now, 32'd8);

    repeat (40) @(negedge clk);
    check("R7 spin on jump", pc_now, 32'd104);

    for (int k = 0; k < NCHK; k++) begin
      read_reg(CHK_REG[k], v);
      check(chk_tag[k], v, CHK_VAL[k]);
    end

    peek_mem = 6'd5;
    #1 check("R5 stored word", peek_mem_val, 32'd8);
    peek_mem = 6'd0;
    #1 check("R5 shifted value stored", peek_mem_val, 32'd80);
    check("R10 program ran", pc_now, 32'd104);

    // R1: reset again clears state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 pc after reset", pc_now, 32'd0);
    read_reg(9, v);
    check("R1 reg after reset", v, 32'd0);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule